// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides where the two ALU operands of a five-stage integer pipeline come from. It sees the instruction now in the execute stage through its two source register numbers. It also sees the two older instructions still in flight: the one in the memory stage and the one in the writeback stage. For each of those older instructions it receives the register it writes, whether it writes at all, and (for the memory stage) whether it is a load. From these it works out a 2-bit select for each operand. It then steers either the register-file read value, the memory-stage ALU result or the writeback value onto that operand.

The whole path is combinational. The producer values come straight from pipeline register outputs, so a forward is set up at the start of a cycle and resolved within that same cycle. A producer's destination is chosen per instruction: register-register operations write their Rd field, while loads and immediate operations write their Rt field. A load still in the memory stage has no data yet, so it never forwards from there. Stalling for that case belongs to a separate hazard unit.

Top module: `opfwd_unit`

## Requirements
- R1: When the memory-stage producer writes (xm_we=1), is not a load, and its destination is nonzero and equal to a source register, that operand's select is 2'b10 and the operand equals xm_result.
- R2: When the writeback-stage producer writes (mw_we=1) to a nonzero destination equal to a source register, and R1 does not apply to that operand, the select is 2'b01 and the operand equals mw_result.
- R3: When both producers qualify for the same source register, the memory-stage producer wins (select 2'b10).
- R4: A producer with its write enable low never causes forwarding from its stage.
- R5: A destination of register 0 never causes forwarding, whatever the write enable.
- R6: A load in the memory stage (xm_load=1) never forwards. The operand falls back to the writeback value when R2 applies, and otherwise to the register file.
- R7: A producer's destination is its rd field when its wr_rd flag is 1 and its rt field when wr_rd is 0. The other field is ignored.
- R8: With no qualifying producer, the select is 2'b00 and the operand equals the register-file read value. This includes the all-zero input state.
- R9: The two operands are resolved independently, so A and B may take different paths in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idx_rs | input | REG_W | First source register of the execute-stage instruction |
| idx_rt | input | REG_W | Second source register of the execute-stage instruction |
| rf_rs_data | input | XLEN | Register-file value read for idx_rs |
| rf_rt_data | input | XLEN | Register-file value read for idx_rt |
| xm_rd | input | REG_W | Rd field of the memory-stage instruction |
| xm_rt | input | REG_W | Rt field of the memory-stage instruction |
| xm_wr_rd | input | 1 | Memory-stage instruction writes rd (1) or rt (0) |
| xm_we | input | 1 | Memory-stage instruction writes a register |
| xm_load | input | 1 | Memory-stage instruction is a load |
| xm_result | input | XLEN | ALU result held in the memory-stage register |
| mw_rd | input | REG_W | Rd field of the writeback-stage instruction |
| mw_rt | input | REG_W | Rt field of the writeback-stage instruction |
| mw_wr_rd | input | 1 | Writeback-stage instruction writes rd (1) or rt (0) |
| mw_we | input | 1 | Writeback-stage instruction writes a register |
| mw_result | input | XLEN | Value about to be written back |
| sel_a | output | 2 | Operand A source: 00 register file, 10 memory stage, 01 writeback |
| sel_b | output | 2 | Operand B source, same encoding |
| opnd_a | output | XLEN | Selected operand A |
| opnd_b | output | XLEN | Selected operand B |

## Verification
The main stimulus replays a dependent chain: an add producer, then a subtract, an AND and an OR that each read the add's result. This separates a forward from the memory stage, a forward from writeback, and the point where the producer has left both stages. Further patterns make both stages claim the same register, which exposes the priority order. Others give each operand a different path, which catches crossed selects. Separate cases break one qualifier at a time (write enable low, register 0, a load in the memory stage, and rd versus rt selection) so that each gate is shown to be necessary by itself.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  // Operand source select encoding
  localparam logic [1:0] SRC_RF = 2'b00;
  localparam logic [1:0] SRC_MW = 2'b01;
  localparam logic [1:0] SRC_XM = 2'b10;

  localparam int NUM_OPND = 2;
endpackage

// File: rtl/opfwd_dst_pick.sv
// Resolves which register a producer writes, and whether it may forward.
module opfwd_dst_pick #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] rt,
  input  logic             wr_rd,
  input  logic             we,
  input  logic             blocked,
  output logic [REG_W-1:0] dst,
  output logic             live
);
  always_comb begin
    dst  = wr_rd ? rd : rt;
    live = we && !blocked && (dst != '0);
  end
endmodule

// File: rtl/opfwd_match.sv
// Per-operand comparison against both producers with priority.
module opfwd_match
  import opfwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] xm_dst,
  input  logic             xm_live,
  input  logic [REG_W-1:0] mw_dst,
  input  logic             mw_live,
  output logic [1:0]       sel
);
  logic hit_xm, hit_mw;
  always_comb begin
    hit_xm = xm_live && (xm_dst == src);
    hit_mw = mw_live && (mw_dst == src);
    if (hit_xm)      sel = SRC_XM;
    else if (hit_mw) sel = SRC_MW;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/opfwd_opmux.sv
// Three-way operand multiplexer.
module opfwd_opmux
  import opfwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      sel,
  input  logic [XLEN-1:0] rf_val,
  input  logic [XLEN-1:0] xm_val,
  input  logic [XLEN-1:0] mw_val,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (sel)
      SRC_XM:  y = xm_val;
      SRC_MW:  y = mw_val;
      default: y = rf_val;
    endcase
  end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
  import opfwd_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int XLEN  = 32
) (
  input  logic [REG_W-1:0] idx_rs,
  input  logic [REG_W-1:0] idx_rt,
  input  logic [XLEN-1:0]  rf_rs_data,
  input  logic [XLEN-1:0]  rf_rt_data,
  input  logic [REG_W-1:0] xm_rd,
  input  logic [REG_W-1:0] xm_rt,
  input  logic             xm_wr_rd,
  input  logic             xm_we,
  input  logic             xm_load,
  input  logic [XLEN-1:0]  xm_result,
  input  logic [REG_W-1:0] mw_rd,
  input  logic [REG_W-1:0] mw_rt,
  input  logic             mw_wr_rd,
  input  logic             mw_we,
  input  logic [XLEN-1:0]  mw_result,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic [XLEN-1:0]  opnd_a,
  output logic [XLEN-1:0]  opnd_b
);
  logic [REG_W-1:0] xm_dst, mw_dst;
  logic             xm_live, mw_live;

  // Load data is not yet available in the memory stage
  opfwd_dst_pick #(.REG_W(REG_W)) u_xm_dst (
    .rd(xm_rd), .rt(xm_rt), .wr_rd(xm_wr_rd), .we(xm_we),
    .blocked(xm_load), .dst(xm_dst), .live(xm_live)
  );

  opfwd_dst_pick #(.REG_W(REG_W)) u_mw_dst (
    .rd(mw_rd), .rt(mw_rt), .wr_rd(mw_wr_rd), .we(mw_we),
    .blocked(1'b0), .dst(mw_dst), .live(mw_live)
  );

  logic [REG_W-1:0] src_v [NUM_OPND];
  logic [XLEN-1:0]  rf_v  [NUM_OPND];
  logic [1:0]       sel_v [NUM_OPND];
  logic [XLEN-1:0]  opn_v [NUM_OPND];

  assign src_v[0] = idx_rs;
  assign src_v[1] = idx_rt;
  assign rf_v[0]  = rf_rs_data;
  assign rf_v[1]  = rf_rt_data;

  for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
    opfwd_match #(.REG_W(REG_W)) u_match (
      .src(src_v[i]), .xm_dst(xm_dst), .xm_live(xm_live),
      .mw_dst(mw_dst), .mw_live(mw_live), .sel(sel_v[i])
    );
    opfwd_opmux #(.XLEN(XLEN)) u_mux (
      .sel(sel_v[i]), .rf_val(rf_v[i]), .xm_val(xm_result),
      .mw_val(mw_result), .y(opn_v[i])
    );
  end

  assign sel_a  = sel_v[0];
  assign sel_b  = sel_v[1];
  assign opnd_a = opn_v[0];
  assign opnd_b = opn_v[1];
endmodule

// File: rtl/opfwd_chk.sv
module opfwd_chk #(
  parameter int REG_W = 5,
  parameter int XLEN  = 32
) (
  input logic [REG_W-1:0] idx_rs,
  input logic [REG_W-1:0] idx_rt,
  input logic [XLEN-1:0]  rf_rs_data,
  input logic [XLEN-1:0]  rf_rt_data,
  input logic [REG_W-1:0] xm_rd,
  input logic [REG_W-1:0] xm_rt,
  input logic             xm_wr_rd,
  input logic             xm_we,
  input logic             xm_load,
  input logic [XLEN-1:0]  xm_result,
  input logic [REG_W-1:0] mw_rd,
  input logic [REG_W-1:0] mw_rt,
  input logic             mw_wr_rd,
  input logic             mw_we,
  input logic [XLEN-1:0]  mw_result,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic [XLEN-1:0]  opnd_a,
  input logic [XLEN-1:0]  opnd_b
);
  always_comb begin
    // R1
    xm_path_chk: assert (sel_a != 2'b10 || opnd_a == xm_result);
    // R2
    mw_path_chk: assert (sel_b != 2'b01 || opnd_b == mw_result);
    // R3
    sel_code_chk: assert (sel_a != 2'b11 && sel_b != 2'b11);
    // R4
    no_we_chk: assert (xm_we || mw_we || (sel_a == 2'b00 && sel_b == 2'b00));
    // R5
    zero_reg_chk: assert (idx_rs != '0 || sel_a == 2'b00);
    // R6
    load_block_chk: assert (!xm_load || (sel_a != 2'b10 && sel_b != 2'b10));
    // R8
    rf_path_chk: assert (sel_b != 2'b00 || opnd_b == rf_rt_data);
  end
endmodule

bind opfwd_unit opfwd_chk #(.REG_W(REG_W), .XLEN(XLEN)) u_chk (.*);

// File: tb/tb_opfwd_unit.sv
`timescale 1ns/1ps
module tb_opfwd_unit;
  localparam int REG_W = 5;
  localparam int XLEN  = 32;
  localparam logic [XLEN-1:0] V_RFA = 32'h1111_0001;
  localparam logic [XLEN-1:0] V_RFB = 32'h2222_0002;
  localparam logic [XLEN-1:0] V_XM  = 32'hAAAA_000A;
  localparam logic [XLEN-1:0] V_MW  = 32'h5555_0005;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [REG_W-1:0] idx_rs = '0, idx_rt = '0;
  logic [XLEN-1:0]  rf_rs_data = '0, rf_rt_data = '0;
  logic [REG_W-1:0] xm_rd = '0, xm_rt = '0, mw_rd = '0, mw_rt = '0;
  logic             xm_wr_rd = 1'b0, xm_we = 1'b0, xm_load = 1'b0;
  logic             mw_wr_rd = 1'b0, mw_we = 1'b0;
  logic [XLEN-1:0]  xm_result = '0, mw_result = '0;
  logic [1:0]       sel_a, sel_b;
  logic [XLEN-1:0]  opnd_a, opnd_b;

  opfwd_unit #(.REG_W(REG_W), .XLEN(XLEN)) dut (.*);

  typedef struct {
    logic [1:0]      sa, sb;
    logic [XLEN-1:0] oa, ob;
    string           tag;
  } exp_t;
  exp_t sb_q[$];

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic logic [XLEN-1:0] pick(logic [1:0] s, logic [XLEN-1:0] rf);
    if (s == 2'b10) return V_XM;
    if (s == 2'b01) return V_MW;
    return rf;
  endfunction

  task automatic drive(input int rs, input int rt,
                       input int xrd, input int xrt, input bit xwrd, input bit xwe, input bit xld,
                       input int mrd, input int mrt, input bit mwrd, input bit mwe,
                       input logic [1:0] esa, input logic [1:0] esb, input string tag);
    exp_t e;
    @(posedge clk);
    idx_rs = REG_W'(rs); idx_rt = REG_W'(rt);
    rf_rs_data = V_RFA; rf_rt_data = V_RFB;
    xm_rd = REG_W'(xrd); xm_rt = REG_W'(xrt); xm_wr_rd = xwrd; xm_we = xwe; xm_load = xld;
    xm_result = V_XM;
    mw_rd = REG_W'(mrd); mw_rt = REG_W'(mrt); mw_wr_rd = mwrd; mw_we = mwe;
    mw_result = V_MW;
    e.sa = esa; e.sb = esb; e.oa = pick(esa, V_RFA); e.ob = pick(esb, V_RFB); e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: samples on the falling edge, after the driver acted on the rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (sel_a !== e.sa || sel_b !== e.sb || opnd_a !== e.oa || opnd_b !== e.ob) begin
          n_fail++;
          $display("FAIL %s: actual sel_a=%b sel_b=%b a=%h b=%h expected sel_a=%b sel_b=%b a=%h b=%h",
                   e.tag, sel_a, sel_b, opnd_a, opnd_b, e.sa, e.sb, e.oa, e.ob);
        end
      end
    end
  end

  initial begin
    // R8: all-zero initial state, register-file path (sampled before any drive)
    @(negedge clk);
    n_chk++;
    if (sel_a !== 2'b00 || sel_b !== 2'b00 || opnd_a !== '0 || opnd_b !== '0) begin
      n_fail++;
      $display("FAIL R8 idle: actual sel_a=%b sel_b=%b expected 00 00", sel_a, sel_b);
    end

    // Dependent chain: add r1,r2,r3 ; sub r4,r1,r5 ; and r6,r7,r1 ; or r8,r1,r9
    // R1: sub reads r1 from memory stage (add writes rd=1)
    drive(1, 5,  1, 3, 1, 1, 0,  0, 0, 0, 0,  2'b10, 2'b00, "R1 sub<-add");
    // R2: and reads r1 from writeback (add), memory stage holds sub rd=4
    drive(7, 1,  4, 5, 1, 1, 0,  1, 3, 1, 1,  2'b00, 2'b01, "R2 and<-add");
    // R8: or reads r1 after add has left both stages
    drive(1, 9,  6, 1, 1, 1, 0,  4, 1, 1, 1,  2'b00, 2'b00, "R8 or regfile");
    // R3: both stages write r3
    drive(3, 3,  3, 0, 1, 1, 0,  3, 0, 1, 1,  2'b10, 2'b10, "R3 priority");
    // R9: A from memory stage, B from writeback
    drive(3, 4,  3, 0, 1, 1, 0,  4, 0, 1, 1,  2'b10, 2'b01, "R9 split");
    // R4: memory-stage write enable low, writeback still forwards
    drive(2, 2,  2, 0, 1, 0, 0,  2, 0, 1, 1,  2'b01, 2'b01, "R4 xm we low");
    // R4: writeback write enable low
    drive(6, 8,  0, 0, 0, 0, 0,  6, 0, 1, 0,  2'b00, 2'b00, "R4 mw we low");
    // R5: register 0 in both stages
    drive(0, 0,  0, 0, 1, 1, 0,  0, 0, 1, 1,  2'b00, 2'b00, "R5 zero reg");
    // R6: load in memory stage writing rt=2, nothing in writeback
    drive(2, 9,  0, 2, 0, 1, 1,  0, 0, 0, 0,  2'b00, 2'b00, "R6 load no fwd");
    // R6: load in memory stage, writeback also writes r2
    drive(2, 2,  0, 2, 0, 1, 1,  2, 0, 1, 1,  2'b01, 2'b01, "R6 load fallback");
    // R7: memory stage writes rt=6 (rd=5 ignored)
    drive(5, 6,  5, 6, 0, 1, 0,  0, 0, 0, 0,  2'b00, 2'b10, "R7 xm rt field");
    // R7: memory stage writes rd=5 (rt=6 ignored)
    drive(5, 6,  5, 6, 1, 1, 0,  0, 0, 0, 0,  2'b10, 2'b00, "R7 xm rd field");
    // R7: writeback writes rt=11 (rd=10 ignored)
    drive(10, 11, 0, 0, 0, 0, 0,  10, 11, 0, 1,  2'b00, 2'b01, "R7 mw rt field");
    // R2: writeback load result forwards (load writes rt)
    drive(12, 13, 0, 0, 0, 0, 0,  0, 12, 0, 1,  2'b01, 2'b00, "R2 mw load");
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule